// File: doc/BRIEF.md
# Serial Peripheral Port with Optional Transmit Holding Byte

This block is a byte-oriented SPI port that works as either a bus master or a selected slave. Software sees four byte registers on a simple register bus: a control byte, a mode byte, a status byte and a data byte. Writing the data register starts or queues a transfer. When a byte completes, the received byte replaces the data register contents, a completion flag is raised, and an interrupt request follows when enabled.

Two transmit modes exist. In plain mode there is no storage beyond the shift register, and a write that arrives while a byte is moving is dropped and reported as a collision. In buffered mode a single holding byte accepts the next write while a byte is moving. The holding byte enters the shift register at the end of the current byte, so consecutive bytes leave with no idle SCK period between them. In this mode the same status bit reports whether the holding byte is occupied.

As a master the block drives SCK and MOSI from its system clock through a selectable divider. As a slave it synchronises SCK, MOSI and the active-low select to the system clock, and it drives MISO according to a sharing option.

Top module: `spi_port`

## Requirements
- R1: In master mode, control bits [6:5] set the SCK period to 4, 16, 64 or 128 system clocks (codes 0 to 3), and successive SCK leading edges are exactly one period apart. In slave mode these bits have no effect on the transfer.
- R2: When a byte completes, the received byte is readable at data address 3, status bit 7 (done) becomes 1, and irq_o is high exactly when done is 1 and control bit 7 (interrupt enable) is 1.
- R3: In plain mode (mode bit 0 = 0), a data write while a byte is moving sets status bit 6, the written byte is never shifted out, and the byte already moving completes normally with 8 SCK periods.
- R4: In buffered mode (mode bit 0 = 1), a data write to an idle shifter starts at once and leaves status bit 6 at 0. A write while a byte is moving fills the holding byte and status bit 6 reads 1 until that byte enters the shifter. A write while the holding byte is full is discarded.
- R5: In buffered mode, a held byte begins on the SCK period right after the current byte ends, so the spacing of leading edges across the byte boundary equals the normal SCK period.
- R6: Control bit 4 selects the bit order: 0 sends and receives the most significant bit first, 1 the least significant bit first.
- R7: Control bit 2 sets the SCK idle level. Control bit 3 = 0 samples on the leading edge and shifts on the trailing edge; 1 shifts on the leading edge and samples on the trailing edge.
- R8: A slave (control bit 1 = 0) shifts only while ss_n_i is low, and SCK edges with ss_n_i high have no effect. With mode bit 1 = 1, miso_oe is low while ss_n_i is high; with mode bit 1 = 0, MISO is driven whenever the slave is enabled.
- R9: Status bits 7 and 6 (plain mode) are cleared only by a status read (address 2) followed by a data access (address 3). A data access without a preceding status read leaves them set.
- R10: A master (control bit 1 = 1, bit 0 enable = 1) ignores ss_n_i and drives SCK and MOSI (sclk_oe = mosi_oe = 1). A slave drives neither and takes SCK and MOSI through synchronisers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier |
| bus_rd | input | 1 | Read qualifier (reads have side effects on flags) |
| bus_addr | input | 2 | 0 control, 1 mode, 2 status, 3 data |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational from address |
| irq_o | output | 1 | Interrupt request |
| sclk_i | input | 1 | SCK from the bus (slave) |
| sclk_o | output | 1 | SCK driven as master |
| sclk_oe | output | 1 | SCK drive enable |
| mosi_i | input | 1 | MOSI from the bus (slave) |
| mosi_o | output | 1 | MOSI driven as master |
| mosi_oe | output | 1 | MOSI drive enable |
| miso_i | input | 1 | MISO from the bus (master) |
| miso_o | output | 1 | MISO driven as slave |
| miso_oe | output | 1 | MISO drive enable |
| ss_n_i | input | 1 | Active-low slave select |

## Verification
The properties watch each cycle. They check that SCK edges never come on adjacent clocks, that the bit counter never passes the byte width, that every completion lands in the data and done flag, that a plain-mode write to a busy shifter raises a collision, that a held byte is taken with no pause at a completion, and that an armed status-then-data sequence clears the done flag. What happens on the wire can only be seen in the bench's scenarios: the bit order and the edge chosen for sampling under each polarity and phase, the measured spacing of SCK edges for each rate including across a buffered byte boundary, that a dropped byte never appears on MOSI, and the slave's response to select and sharing options.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    // Control byte layout (address 0)
    typedef struct packed {
        logic       irq_en;     // [7]
        logic [1:0] rate;       // [6:5]
        logic       lsb_first;  // [4]
        logic       cpha;       // [3]
        logic       cpol;       // [2]
        logic       master;     // [1]
        logic       enable;     // [0]
    } ctrl_t;

    // Mode byte layout (address 1)
    typedef struct packed {
        logic [5:0] spare;
        logic       miso_float; // [1]
        logic       enhanced;   // [0]
    } mode_t;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_MODE = 2'd1,
        REG_STAT = 2'd2,
        REG_DATA = 2'd3
    } reg_addr_e;

    localparam int HALF_W = 7;

    // Half an SCK period in system clocks for each rate code
    function automatic logic [HALF_W-1:0] half_period(input logic [1:0] rate);
        case (rate)
            2'd0:    return 7'd2;
            2'd1:    return 7'd8;
            2'd2:    return 7'd32;
            default: return 7'd64;
        endcase
    endfunction

endpackage

// File: rtl/spi_port_sckgen.sv
module spi_port_sckgen
    import spi_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       cpol,
    input  logic [1:0] rate,
    output logic       sclk,
    output logic       lead,
    output logic       trail
);
    logic [HALF_W-1:0] hcnt;
    logic [HALF_W-1:0] half;
    logic              phase;   // 0: next edge is a leading edge
    logic              tick;

    assign half  = half_period(rate);
    assign tick  = run && (hcnt == half - 1'b1);
    assign lead  = tick && !phase;
    assign trail = tick && phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            hcnt  <= '0;
            phase <= 1'b0;
            sclk  <= 1'b0;
        end else if (!run) begin
            hcnt  <= '0;
            phase <= 1'b0;
            sclk  <= cpol;
        end else if (tick) begin
            hcnt  <= '0;
            phase <= ~phase;
            sclk  <= ~sclk;
        end else begin
            hcnt  <= hcnt + 1'b1;
        end
    end

    // R1: two SCK edges are never closer than two system clocks
    p_edge_spacing_r1: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/spi_port_shifter.sv
module spi_port_shifter #(
    parameter int DW = 8,
    localparam int CW = $clog2(DW + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          clear,
    input  logic          lead,
    input  logic          trail,
    input  logic          cpha,
    input  logic          lsb_first,
    input  logic          sdi,
    output logic          sdo,
    output logic          done,
    output logic          active,
    output logic [DW-1:0] rx_word
);
    logic [DW-1:0] tx_q, rx_q, rx_next;
    logic [CW-1:0] cnt;
    logic          smp, shft;

    assign smp     = cpha ? trail : lead;
    assign shft    = cpha ? (lead && cnt != '0) : trail;
    assign rx_next = lsb_first ? {sdi, rx_q[DW-1:1]} : {rx_q[DW-2:0], sdi};
    assign done    = trail && (cnt == (cpha ? CW'(DW - 1) : CW'(DW)));
    assign rx_word = cpha ? rx_next : rx_q;
    assign sdo     = lsb_first ? tx_q[0] : tx_q[DW-1];
    assign active  = (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= '0;
            rx_q <= '0;
            cnt  <= '0;
        end else if (load) begin
            tx_q <= load_data;
            cnt  <= '0;
        end else if (clear || done) begin
            cnt  <= '0;
        end else begin
            if (smp) begin
                rx_q <= rx_next;
                cnt  <= cnt + 1'b1;
            end
            if (shft) begin
                tx_q <= lsb_first ? (tx_q >> 1) : (tx_q << 1);
            end
        end
    end

    // R2: the bit counter never runs past one byte
    p_count_bound_r2: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DW));

    // R2: a completed byte always restarts the bit count
    p_done_restart_r2: assert property (@(posedge clk) disable iff (rst)
        done |=> cnt == '0);

endmodule

// File: rtl/spi_port.sv
module spi_port
    import spi_port_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [1:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq_o,
    input  logic          sclk_i,
    output logic          sclk_o,
    output logic          sclk_oe,
    input  logic          mosi_i,
    output logic          mosi_o,
    output logic          mosi_oe,
    input  logic          miso_i,
    output logic          miso_o,
    output logic          miso_oe,
    input  logic          ss_n_i
);
    localparam int SYNC_N = 2;

    ctrl_t         ctrl;
    mode_t         mode;
    reg_addr_e     addr;
    logic [DW-1:0] rxd, buf_q, ld_data, sh_rx;
    logic          done_f, col_f, arm_done, arm_col, buf_full, m_busy;
    logic          wr_ctrl, wr_mode, wr_data, rd_stat, acc_data;
    logic          idle, direct_ld, buf_ld, ld, col_stat;
    logic          sh_done, sh_active, sh_sdo, sh_clear;
    logic          m_run, m_sclk, m_lead, m_trail;
    logic          s_lead, s_trail, s_rise, s_fall, s_sel;
    logic          lead, trail, sdi;
    logic [SYNC_N:0]   sck_q;
    logic [SYNC_N-1:0] mosi_q, ss_q;

    // ---------------- register bus decode ----------------
    assign addr     = reg_addr_e'(bus_addr);
    assign wr_ctrl  = bus_sel && bus_wr && addr == REG_CTRL;
    assign wr_mode  = bus_sel && bus_wr && addr == REG_MODE;
    assign wr_data  = bus_sel && bus_wr && addr == REG_DATA;
    assign rd_stat  = bus_sel && bus_rd && addr == REG_STAT;
    assign acc_data = bus_sel && (bus_wr || bus_rd) && addr == REG_DATA;

    // ---------------- slave input synchronisers ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q  <= '0;
            mosi_q <= '0;
            ss_q   <= '1;
        end else begin
            sck_q  <= {sck_q[SYNC_N-1:0], sclk_i};
            mosi_q <= {mosi_q[SYNC_N-2:0], mosi_i};
            ss_q   <= {ss_q[SYNC_N-2:0], ss_n_i};
        end
    end

    assign s_sel   = !ss_q[SYNC_N-1];
    assign s_rise  = sck_q[SYNC_N-1] && !sck_q[SYNC_N];
    assign s_fall  = !sck_q[SYNC_N-1] && sck_q[SYNC_N];
    assign s_lead  = s_sel && (ctrl.cpol ? s_fall : s_rise);
    assign s_trail = s_sel && (ctrl.cpol ? s_rise : s_fall);

    // ---------------- master clock generator ----------------
    assign m_run = m_busy && ctrl.master && ctrl.enable;

    spi_port_sckgen u_sckgen (
        .clk   (clk),
        .rst   (rst),
        .run   (m_run),
        .cpol  (ctrl.cpol),
        .rate  (ctrl.rate),
        .sclk  (m_sclk),
        .lead  (m_lead),
        .trail (m_trail)
    );

    // ---------------- shared shift engine ----------------
    assign lead     = ctrl.master ? m_lead  : s_lead;
    assign trail    = ctrl.master ? m_trail : s_trail;
    assign sdi      = ctrl.master ? miso_i  : mosi_q[SYNC_N-1];
    assign sh_clear = !ctrl.enable || (!ctrl.master && !s_sel);
    assign idle     = ctrl.master ? !m_busy : !sh_active;

    always_comb begin
        direct_ld = wr_data && idle && !buf_full;
        buf_ld    = buf_full && (idle || (sh_done && mode.enhanced));
        ld        = direct_ld || buf_ld;
        ld_data   = buf_ld ? buf_q : bus_wdata;
    end

    spi_port_shifter #(.DW(DW)) u_shifter (
        .clk       (clk),
        .rst       (rst),
        .load      (ld),
        .load_data (ld_data),
        .clear     (sh_clear),
        .lead      (lead),
        .trail     (trail),
        .cpha      (ctrl.cpha),
        .lsb_first (ctrl.lsb_first),
        .sdi       (sdi),
        .sdo       (sh_sdo),
        .done      (sh_done),
        .active    (sh_active),
        .rx_word   (sh_rx)
    );

    // ---------------- registers and flags ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            mode     <= '0;
            rxd      <= '0;
            buf_q    <= '0;
            buf_full <= 1'b0;
            done_f   <= 1'b0;
            col_f    <= 1'b0;
            arm_done <= 1'b0;
            arm_col  <= 1'b0;
            m_busy   <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl <= ctrl_t'(bus_wdata[7:0]);
            if (wr_mode) mode <= mode_t'(bus_wdata[7:0]);

            // status read arms, following data access clears
            if (rd_stat) begin
                arm_done <= done_f;
                arm_col  <= col_f;
            end else if (acc_data) begin
                arm_done <= 1'b0;
                arm_col  <= 1'b0;
                if (arm_done) done_f <= 1'b0;
                if (arm_col)  col_f  <= 1'b0;
            end

            if (wr_data && !idle) begin
                if (!mode.enhanced) begin
                    col_f <= 1'b1;
                end else if (!buf_full) begin
                    buf_q    <= bus_wdata;
                    buf_full <= 1'b1;
                end
            end
            if (buf_ld) buf_full <= 1'b0;

            if (ld && ctrl.master && ctrl.enable) begin
                m_busy <= 1'b1;
            end else if (sh_done || !ctrl.enable || !ctrl.master) begin
                m_busy <= 1'b0;
            end

            if (sh_done) begin
                rxd    <= sh_rx;
                done_f <= 1'b1;
            end
        end
    end

    assign col_stat = mode.enhanced ? buf_full : col_f;

    always_comb begin
        case (addr)
            REG_CTRL: bus_rdata = DW'(ctrl);
            REG_MODE: bus_rdata = DW'(mode);
            REG_STAT: bus_rdata = {done_f, col_stat, {(DW-3){1'b0}}, !idle};
            default:  bus_rdata = rxd;
        endcase
    end

    // ---------------- pins ----------------
    assign irq_o   = done_f && ctrl.irq_en;
    assign sclk_o  = m_sclk;
    assign sclk_oe = ctrl.enable && ctrl.master;
    assign mosi_o  = sh_sdo;
    assign mosi_oe = ctrl.enable && ctrl.master;
    assign miso_o  = sh_sdo;
    assign miso_oe = ctrl.enable && !ctrl.master && (s_sel || !mode.miso_float);

    // ---------------- properties ----------------
    // R2: a completed byte is captured and flagged
    p_done_capture_r2: assert property (@(posedge clk) disable iff (rst)
        sh_done |=> done_f && rxd == $past(sh_rx));

    // R3: plain-mode write to a busy shifter raises a collision
    p_collision_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_data && !idle && !mode.enhanced) |=> col_f);

    // R5: a held byte is taken at completion with the clock kept running
    p_no_gap_r5: assert property (@(posedge clk) disable iff (rst)
        (sh_done && mode.enhanced && buf_full && ctrl.master && ctrl.enable)
        |=> m_busy && !buf_full);

    // R4: a held byte never waits on an idle shifter
    p_drain_r4: assert property (@(posedge clk) disable iff (rst)
        (idle && buf_full) |=> !buf_full);

    // R9: an armed status-then-data sequence clears done
    p_flag_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (acc_data && arm_done && !sh_done) |=> !done_f);

endmodule

// File: tb/tb_spi_port.sv
module tb_spi_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq_o, sclk_o, sclk_oe, mosi_o, mosi_oe, miso_o, miso_oe;
    logic       sclk_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1;
    logic       miso_m;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    spi_port #(.DW(8)) dut (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o),
        .sclk_i(sclk_i), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
        .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_m), .miso_o(miso_o), .miso_oe(miso_oe),
        .ss_n_i(ss_n_i)
    );

    // ---------------- bench-side slave model for master tests ----------------
    logic       mdl_clr = 1'b0;
    logic       cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb = 1'b0;
    logic [7:0] pat = 8'h00;
    logic       prev_sclk = 1'b0;
    int         cyc = 0, n_lead = 0, n_trail = 0, n_smp = 0;
    int         last_lead = -1, min_gap = 100000, max_gap = 0;
    logic [7:0] cap [0:3];
    int         idx;

    always @(negedge clk) begin
        cyc++;
        if (mdl_clr) begin
            n_lead = 0; n_trail = 0; n_smp = 0;
            last_lead = -1; min_gap = 100000; max_gap = 0;
            prev_sclk = sclk_o;
            for (int k = 0; k < 4; k++) cap[k] = 8'h00;
        end else if (sclk_o != prev_sclk) begin
            prev_sclk = sclk_o;
            if (sclk_o != cfg_cpol) begin
                if (last_lead >= 0) begin
                    if (cyc - last_lead < min_gap) min_gap = cyc - last_lead;
                    if (cyc - last_lead > max_gap) max_gap = cyc - last_lead;
                end
                last_lead = cyc;
                n_lead++;
                if (!cfg_cpha) begin
                    cap[(n_smp/8)%4][cfg_lsb ? n_smp%8 : 7-(n_smp%8)] = mosi_o;
                    n_smp++;
                end
            end else begin
                n_trail++;
                if (cfg_cpha) begin
                    cap[(n_smp/8)%4][cfg_lsb ? n_smp%8 : 7-(n_smp%8)] = mosi_o;
                    n_smp++;
                end
            end
        end
    end

    always_comb begin
        if (cfg_cpha) idx = (n_lead == 0) ? 0 : (n_lead - 1) % 8;
        else          idx = n_trail % 8;
        miso_m = pat[cfg_lsb ? idx : 7 - idx];
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic bwr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic brd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic model_clear();
        @(posedge clk); mdl_clr = 1'b1;
        @(posedge clk); mdl_clr = 1'b0;
    endtask

    task automatic wait_irq();
        for (int i = 0; i < 4000 && !irq_o; i++) @(negedge clk);
    endtask

    // {ctrl, tx byte, miso pattern, SCK period}
    localparam logic [31:0] VEC [6] = '{
        32'h83_A5_3C_04,   // rate 0, idle low, sample leading, msb first
        32'hA7_81_7E_10,   // rate 1, idle high
        32'h8B_C3_96_04,   // phase 1
        32'h9F_1E_E1_04,   // idle high, phase 1, lsb first
        32'hD3_69_0F_40,   // rate 2, lsb first
        32'hE3_F0_55_80    // rate 3
    };

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL all watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [7:0] rv;
        logic [7:0] scap;
        logic [7:0] ctl;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // reset state
        brd(2'd2, rv); chk("reset status", rv, 8'h00);
        brd(2'd0, rv); chk("reset ctrl", rv, 8'h00);
        chk("reset sclk R7", sclk_o, 1'b0);
        chk("reset irq R2", irq_o, 1'b0);
        chk("reset oe R10", {sclk_oe, mosi_oe, miso_oe}, 3'b000);

        // table of master transfers; ss_n_i held high throughout (R10)
        for (int v = 0; v < 6; v++) begin
            ctl      = VEC[v][31:24];
            cfg_cpol = ctl[2];
            cfg_cpha = ctl[3];
            cfg_lsb  = ctl[4];
            pat      = VEC[v][15:8];
            bwr(2'd1, 8'h00);
            bwr(2'd0, ctl);
            repeat (3) @(negedge clk);
            chk("idle level R7", sclk_o, cfg_cpol);
            model_clear();
            bwr(2'd3, VEC[v][23:16]);
            wait_irq();
            repeat (4) @(negedge clk);
            chk("irq R2", irq_o, 1'b1);
            chk("mosi order R6 R7", cap[0], VEC[v][23:16]);
            chk("period R1", {min_gap[15:0], max_gap[15:0]},
                {8'h00, VEC[v][7:0], 8'h00, VEC[v][7:0]});
            chk("master drives R10", {sclk_oe, mosi_oe}, 2'b11);
            brd(2'd2, rv); chk("done flag R2", rv[7], 1'b1);
            brd(2'd3, rv); chk("rx data R2 R6", rv, pat);
            brd(2'd2, rv); chk("cleared R9", rv[7:6], 2'b00);
        end

        // plain-mode collision
        cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_lsb = 1'b0; pat = 8'h00;
        bwr(2'd1, 8'h00);
        bwr(2'd0, 8'h83);
        repeat (3) @(negedge clk);
        model_clear();
        bwr(2'd3, 8'hA5);
        bwr(2'd3, 8'h11);
        wait_irq();
        repeat (40) @(negedge clk);
        chk("one byte only R3", n_lead, 8);
        chk("current byte kept R3", cap[0], 8'hA5);
        brd(2'd3, rv);
        brd(2'd2, rv); chk("flags survive data-only access R9 R3", rv[7:6], 2'b11);
        brd(2'd3, rv);
        brd(2'd2, rv); chk("flags cleared R9", rv[7:6], 2'b00);
        chk("irq dropped R2", irq_o, 1'b0);

        // buffered mode, back-to-back
        pat = 8'hA5;
        bwr(2'd1, 8'h01);
        bwr(2'd0, 8'h83);
        repeat (3) @(negedge clk);
        model_clear();
        bwr(2'd3, 8'h3C);
        brd(2'd2, rv); chk("direct load R4", rv[6], 1'b0);
        bwr(2'd3, 8'hC5);
        brd(2'd2, rv); chk("holding full R4", rv[6], 1'b1);
        bwr(2'd3, 8'h99);
        repeat (120) @(negedge clk);
        chk("two bytes only R4", n_lead, 16);
        chk("first byte R5", cap[0], 8'h3C);
        chk("held byte R5", cap[1], 8'hC5);
        chk("no gap R5", {min_gap[15:0], max_gap[15:0]}, 32'h0004_0004);
        brd(2'd2, rv); chk("holding empty R4", rv[6], 1'b0);
        brd(2'd3, rv); chk("last rx R2", rv, 8'hA5);

        // slave mode, rate bits set to 3 (ignored), irq disabled, float on
        bwr(2'd1, 8'h02);
        bwr(2'd0, 8'h61);
        repeat (3) @(negedge clk);
        bwr(2'd3, 8'h96);
        repeat (2) @(negedge clk);
        chk("float while deselected R8", miso_oe, 1'b0);
        chk("slave drives no sck/mosi R10", {sclk_oe, mosi_oe}, 2'b00);
        for (int i = 0; i < 8; i++) begin
            repeat (8) @(negedge clk); sclk_i = 1'b1;
            repeat (8) @(negedge clk); sclk_i = 1'b0;
        end
        repeat (8) @(negedge clk);
        brd(2'd2, rv); chk("deselected edges ignored R8", rv[7], 1'b0);
        brd(2'd3, rv);
        ss_n_i = 1'b0;
        repeat (4) @(negedge clk);
        chk("selected drives miso R8", miso_oe, 1'b1);
        scap = 8'h00;
        for (int i = 0; i < 8; i++) begin
            mosi_i = 8'h4D >> (7 - i);
            repeat (8) @(negedge clk);
            scap[7 - i] = miso_o;
            sclk_i = 1'b1;
            repeat (8) @(negedge clk);
            sclk_i = 1'b0;
        end
        repeat (8) @(negedge clk);
        chk("slave miso bits R8 R6", scap, 8'h96);
        brd(2'd2, rv); chk("slave done R2", rv[7], 1'b1);
        chk("irq masked R2", irq_o, 1'b0);
        brd(2'd3, rv); chk("slave rx R8 R1", rv, 8'h4D);
        ss_n_i = 1'b1;
        bwr(2'd1, 8'h00);
        repeat (3) @(negedge clk);
        chk("shared line driven R8", miso_oe, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule